// File: doc/BRIEF.md
# GPIO Edge Interrupt Unit

This block watches 28 general-purpose input lines and turns their transitions into interrupt requests. Each line has its own enable for a low-to-high transition and its own enable for a high-to-low transition. When an enabled transition is seen, a sticky pending bit is set for that line. The pending bit stays set until software writes a 1 to it.

Lines 0 to 7 each drive their own interrupt output. The pending bits of lines 8 to 27 are ORed into one summary interrupt. A wake mask picks which pending sources may raise a wake request. It has one bit for each low line and one bit for the upper group.

Software reaches the block through a small register port. It has a 2-bit address, a write strobe, 32-bit write data and registered read data. The inputs are asynchronous to the clock and are synchronised inside the block.

Top module: `gpio_edge_irq`

## Requirements
- R1: A line whose rise-enable bit is set gets its pending bit set when the input goes from 0 to 1. The pending bit is visible by the third rising clock edge after the input changes, because of the two-flop synchroniser and the edge register.
- R2: A line whose fall-enable bit is set gets its pending bit set when the input goes from 1 to 0. With both enables set, either direction sets the bit.
- R3: A pending bit is sticky. It stays set after the input returns to its earlier level, and it stays set until it is cleared by a write.
- R4: A write to the pending register (address 2) clears every bit written as 1 and leaves every bit written as 0 unchanged. Writing 0x0FFFFFFF clears all 28 bits.
- R5: If an enabled edge on a line is detected in the same cycle that a write clears that line's pending bit, the bit ends up set.
- R6: Output `irq_low[i]` (i from 0 to 7) equals pending bit i.
- R7: Output `irq_high` is 1 exactly when any pending bit from 8 to 27 is set. It follows the pending bits one cycle later.
- R8: With both enable registers at zero, no transition sets a pending bit. Bits that are already pending stay set.
- R9: `wake_req` is 1 when a pending source has its wake bit set. In the wake register (address 3), bit i (0 to 7) enables line i, and bit 8 enables the group of lines 8 to 27. `wake_req` follows one cycle after the pending bits.
- R10: A synchronous active-high reset clears both enable registers, all pending bits, the wake register and all outputs.
- R11: The register map is: address 0 rise enables, 1 fall enables, 2 pending bits, 3 wake mask. Unused upper bits read as 0. `bus_rdata` shows the register selected by `bus_addr` one clock after the address is sampled, and a read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins | input | 28 | Asynchronous input lines |
| bus_addr | input | 2 | Register select |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_low | output | 8 | Per-line interrupts for lines 0 to 7 |
| irq_high | output | 1 | Summary interrupt for lines 8 to 27 |
| wake_req | output | 1 | Wake request |

## Verification
A clear write and a freshly detected edge on the same line can fall in the same cycle. The bench provokes this by changing an input exactly two falling clock edges before it drives the write-one-to-clear strobe, so both reach the pending register on the same rising edge. It then reads the pending register and expects the collided bit to be set and a neighbouring bit, cleared in the same write, to be 0. The checker also asserts that a bit with a same-cycle edge is never left at 0 after a clear.

// File: rtl/gei_pkg.sv
package gei_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_RISE = 2'd0,
    REG_FALL = 2'd1,
    REG_PEND = 2'd2,
    REG_WAKE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gei_sync.sv
module gei_sync #(
  parameter int W      = 28,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gei_edge.sv
module gei_edge #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] hit
);
  logic [W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= level;
  end

  always_comb begin
    hit = (level & ~last_q & rise_en) | (~level & last_q & fall_en);
  end
endmodule

// File: rtl/gei_pending.sv
module gei_pending #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set_mask,
  output logic [W-1:0] pend
);
  logic [W-1:0] keep;

  always_comb begin
    keep = clr_we ? (pend & ~clr_mask) : pend;
  end

  // A fresh edge is ORed in after the clear, so it wins a collision.
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= keep | set_mask;
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NPIN   = 28,
  parameter int NLOW   = 8,
  parameter int DW     = 32,
  parameter int STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NPIN-1:0]            pins,
  input  logic [gei_pkg::ADDR_W-1:0] bus_addr,
  input  logic                       bus_wen,
  input  logic [DW-1:0]              bus_wdata,
  output logic [DW-1:0]              bus_rdata,
  output logic [NLOW-1:0]            irq_low,
  output logic                       irq_high,
  output logic                       wake_req
);
  import gei_pkg::*;

  localparam int WAKE_W = NLOW + 1;

  logic [NPIN-1:0]   rise_en, fall_en, pins_s, hit, pend;
  logic [WAKE_W-1:0] wake_en;
  logic [WAKE_W-1:0] src_vec;
  logic              pend_wr;
  logic [DW-1:0]     rd_mux;

  gei_sync #(.W(NPIN), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pins), .dout(pins_s)
  );

  gei_edge #(.W(NPIN)) u_edge (
    .clk(clk), .rst(rst), .level(pins_s),
    .rise_en(rise_en), .fall_en(fall_en), .hit(hit)
  );

  assign pend_wr = bus_wen && (bus_addr == REG_PEND);

  gei_pending #(.W(NPIN)) u_pend (
    .clk(clk), .rst(rst), .clr_we(pend_wr),
    .clr_mask(bus_wdata[NPIN-1:0]), .set_mask(hit), .pend(pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_en <= '0;
      fall_en <= '0;
      wake_en <= '0;
    end else if (bus_wen) begin
      case (reg_sel_e'(bus_addr))
        REG_RISE: rise_en <= bus_wdata[NPIN-1:0];
        REG_FALL: fall_en <= bus_wdata[NPIN-1:0];
        REG_WAKE: wake_en <= bus_wdata[WAKE_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_sel_e'(bus_addr))
      REG_RISE: rd_mux[NPIN-1:0]   = rise_en;
      REG_FALL: rd_mux[NPIN-1:0]   = fall_en;
      REG_PEND: rd_mux[NPIN-1:0]   = pend;
      REG_WAKE: rd_mux[WAKE_W-1:0] = wake_en;
      default:  rd_mux = '0;
    endcase
  end

  always_comb begin
    src_vec = {(|pend[NPIN-1:NLOW]), pend[NLOW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_high  <= 1'b0;
      wake_req  <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      irq_high  <= src_vec[NLOW];
      wake_req  <= |(src_vec & wake_en);
    end
  end

  assign irq_low = pend[NLOW-1:0];
endmodule

// File: rtl/gei_checker.sv
module gei_checker #(
  parameter int NPIN = 28,
  parameter int NLOW = 8,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_wen,
  input logic [1:0]      bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [NPIN-1:0] pend,
  input logic [NPIN-1:0] hit,
  input logic [NPIN-1:0] rise_en,
  input logic [NPIN-1:0] fall_en,
  input logic            irq_high
);
  AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(hit)) == $past(hit)));  // R5

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && bus_addr == 2'd2) |=>
      ((pend & $past(bus_wdata[NPIN-1:0]) & ~$past(hit)) == '0));  // R4

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(hit)) == '0));  // R3

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rise_en == '0 && fall_en == '0) |-> (hit == '0));  // R8

  AST_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_high == $past(|pend[NPIN-1:NLOW])));  // R7
endmodule

bind gpio_edge_irq gei_checker #(.NPIN(NPIN), .NLOW(NLOW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pend(pend), .hit(hit),
  .rise_en(rise_en), .fall_en(fall_en), .irq_high(irq_high)
);

// File: tb/gpio_edge_irq_bench.sv
`timescale 1ns/1ps
module gpio_edge_irq_bench;
  localparam int NPIN = 28;
  localparam int NLOW = 8;
  localparam logic [27:0] ALL = 28'h0FFFFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [27:0] pins = '0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_low;
  logic        irq_high, wake_req;

  int n_chk = 0, n_bad = 0;
  logic [27:0] m_pend = '0, m_rise = '0, m_fall = '0;
  logic [8:0]  m_wake = '0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  gpio_edge_irq u_gpio_edge_irq (
    .clk(clk), .rst(rst), .pins(pins), .bus_addr(bus_addr),
    .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_low(irq_low), .irq_high(irq_high), .wake_req(wake_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [27:0] edges(input logic [27:0] o, input logic [27:0] n,
                                        input logic [27:0] r, input logic [27:0] f);
    return (n & ~o & r) | (~n & o & f);
  endfunction

  function automatic logic exp_wake(input logic [27:0] p, input logic [8:0] w);
    return |({(|p[27:8]), p[7:0]} & w);
  endfunction

  task automatic drive_pins(input logic [27:0] n);
    @(negedge clk);
    m_pend = m_pend | edges(pins, n, m_rise, m_fall);
    pins = n;
    repeat (5) @(negedge clk);
  endtask

  task automatic check_outputs(input string tag);
    rdreg(2'd2, rd);
    check({tag, " R3 pending"}, rd, {4'h0, m_pend});
    check("R6 irq_low", {24'h0, irq_low}, {24'h0, m_pend[7:0]});
    check("R7 irq_high", {31'h0, irq_high}, {31'h0, |m_pend[27:8]});
    check("R9 wake_req", {31'h0, wake_req}, {31'h0, exp_wake(m_pend, m_wake)});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 / R11: reset values read as zero
    for (int a = 0; a < 4; a++) begin
      rdreg(a[1:0], rd);
      check("R10 reset register", rd, 32'h0);
    end
    check("R10 reset outputs", {22'h0, irq_low, irq_high, wake_req}, 32'h0);

    // R1: rising only on line 3 and line 12
    m_rise = 28'h0001008; wr(2'd0, {4'h0, m_rise});
    rdreg(2'd0, rd); check("R11 rise readback", rd, {4'h0, m_rise});
    drive_pins(28'h0001008);
    check_outputs("R1");
    drive_pins(28'h0000000);            // falling ignored, bits stay (R3)
    check_outputs("R3");

    // R2: both edges on line 20
    wr(2'd2, {4'h0, ALL}); m_pend = '0;
    m_rise = 28'h0100000; m_fall = 28'h0100000;
    wr(2'd0, {4'h0, m_rise}); wr(2'd1, {4'h0, m_fall});
    drive_pins(28'h0100000);
    check_outputs("R2");
    wr(2'd2, {4'h0, ALL}); m_pend = '0;
    drive_pins(28'h0000000);
    check_outputs("R2 fall");

    // R5: clear and edge land in the same cycle on line 3; line 4 only cleared
    m_rise = 28'h0000018; m_fall = '0;
    wr(2'd1, 32'h0); wr(2'd0, {4'h0, m_rise});
    wr(2'd2, {4'h0, ALL}); m_pend = '0;
    drive_pins(28'h0000010);            // line 4 pending
    @(negedge clk); pins = 28'h0000018; // line 3 rises
    @(negedge clk);
    @(negedge clk); bus_addr = 2'd2; bus_wdata = 32'h18; bus_wen = 1'b1;
    @(negedge clk); bus_wen = 1'b0;
    rdreg(2'd2, rd);
    check("R5 collision keeps bit", rd, 32'h00000008);
    m_pend = 28'h0000008;

    // R4: write-0 bits untouched, all-ones clears all
    wr(2'd2, 32'h0); rdreg(2'd2, rd); check("R4 zero write", rd, 32'h8);
    wr(2'd2, {4'h0, ALL}); m_pend = '0;
    rdreg(2'd2, rd); check("R4 clear all", rd, 32'h0);

    // R8: enables off; pending survives, nothing new recorded
    m_rise = ALL; wr(2'd0, {4'h0, m_rise});
    drive_pins(28'h0000118);
    m_rise = '0; m_fall = '0; wr(2'd0, 32'h0);
    drive_pins(28'h0FFFFFFF);
    drive_pins(28'h0000000);
    check_outputs("R8");

    // R9: wake bit for the high group only
    m_wake = 9'h100; wr(2'd3, {23'h0, m_wake});
    repeat (2) @(negedge clk);
    check_outputs("R9");

    // Random mix
    for (int i = 0; i < 40; i++) begin
      m_rise = $urandom() & ALL; m_fall = $urandom() & ALL;
      m_wake = $urandom() & 9'h1FF;
      wr(2'd0, {4'h0, m_rise}); wr(2'd1, {4'h0, m_fall}); wr(2'd3, {23'h0, m_wake});
      drive_pins($urandom() & ALL);
      check_outputs("R1 R2 random");
      begin
        logic [27:0] c = $urandom() & ALL;
        wr(2'd2, {4'h0, c});
        m_pend = m_pend & ~c;
        repeat (2) @(negedge clk);
        check_outputs("R4 random");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule